// File: doc/BRIEF.md
# Dual Calendar Alarm Controller

This block watches the running calendar time and compares it against two programmable alarm sets. Each alarm set holds a value for every time field and a per-field compare enable. A field whose compare enable is clear is a wildcard. The comparison is taken only on the one-second tick, so one match can raise a flag at most once in any second.

Each alarm has its own enable. A shared mode bit selects one of two behaviours. In one-shot mode an alarm fires on one match and then stays disarmed until its enable is dropped. The interrupt output then follows the OR of the status flags as a level. In repeating mode every matching tick sets the flag and emits an interrupt pulse of fixed length. Alarm 0 has priority in repeating mode: when both enables are set, alarm 1 is ignored. While the frequency output is enabled, neither alarm fires.

The flags are cleared by a status read. The block counts falling edges of the serial clock while a read is in progress, and the eighth falling edge clears both flags.

Top module: `cal_alarm_ctrl`

## Requirements
- R1: When tick_i is high, alarm k is enabled, fout_en_i is low, and every compared field of time_i equals the matching field of the alarm value, flag_o[k] is 1 from the next clock edge. A compared field that differs prevents the set.
- R2: Field n occupies bits [n*FW +: FW] of time_i and of the alarm values. A 0 in bit n of an alarm's compare-enable vector makes field n a don't-care.
- R3: Without tick_i, no flag bit goes from 0 to 1, even when a match is held.
- R4: In one-shot mode (rpt_mode_i = 0), irq_o equals the OR of flag_o and stays high until the flags are cleared.
- R5: In one-shot mode an alarm fires once. Later matches do not set its flag again until its enable has been driven low and then high again.
- R6: In one-shot mode both alarms may be enabled together, and a common matching tick sets both flag bits.
- R7: In repeating mode (rpt_mode_i = 1), every matching tick sets the flag and makes irq_o high for exactly PULSE_CYC clock cycles, starting at the tick edge.
- R8: In repeating mode, with alm_en_i[0] set, alarm 1 never fires. With only alm_en_i[1] set, alarm 1 fires.
- R9: While fout_en_i is 1, neither flag is set.
- R10: While sr_rd_i is high, the eighth sr_scl_fall_i strobe clears both flags. Seven strobes leave them set. When sr_rd_i drops, the strobe count restarts.
- R11: In repeating mode, clearing the enables stops all firing, and irq_o stays low.
- R12: After reset, flag_o is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second tick, one cycle wide |
| time_i | input | NF*FW | Current time fields |
| alm0_val_i | input | NF*FW | Alarm 0 field values |
| alm0_cmp_i | input | NF | Alarm 0 per-field compare enables |
| alm1_val_i | input | NF*FW | Alarm 1 field values |
| alm1_cmp_i | input | NF | Alarm 1 per-field compare enables |
| alm_en_i | input | 2 | Per-alarm enable |
| rpt_mode_i | input | 1 | 0 one-shot, 1 repeating pulse |
| fout_en_i | input | 1 | Frequency output enabled, blocks alarms |
| sr_rd_i | input | 1 | Status read in progress |
| sr_scl_fall_i | input | 1 | Serial clock falling-edge strobe |
| flag_o | output | 2 | Alarm status flags |
| irq_o | output | 1 | Interrupt output |

## Verification
The hardest state to reach from the ports is the disarmed one-shot alarm. A first match fires the alarm, a status read then clears the flag, and a second matching tick must leave the flag clear. The bench then drops the enable, raises it again and shows that the alarm fires once more. The clear counter also needs targeted stimulus: one read is stopped after seven strobes, and another is split by a drop of sr_rd_i after four, so neither one reaches eight.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int unsigned NUM_ALM = 2;
  typedef enum logic {MODE_ONESHOT = 1'b0, MODE_REPEAT = 1'b1} alm_mode_e;
endpackage

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int unsigned NF = 6,
  parameter int unsigned FW = 8,
  localparam int unsigned TW = NF * FW
) (
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] val_i,
  input  logic [NF-1:0] cmp_i,
  output logic          hit_o
);
  logic [NF-1:0] fld_ok;

  for (genvar n = 0; n < NF; n++) begin : g_fld
    assign fld_ok[n] = !cmp_i[n] || (time_i[n*FW +: FW] == val_i[n*FW +: FW]);
  end

  assign hit_o = &fld_ok;
endmodule

// File: rtl/cal_sr_clear.sv
module cal_sr_clear #(
  parameter int unsigned SR_BITS = 8,
  localparam int unsigned CW = $clog2(SR_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sr_rd_i,
  input  logic sr_scl_fall_i,
  output logic clr_o
);
  logic [CW-1:0] cnt_q;

  assign clr_o = sr_rd_i && sr_scl_fall_i && (cnt_q == CW'(SR_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (!sr_rd_i)                            cnt_q <= '0;
    else if (sr_scl_fall_i && cnt_q != CW'(SR_BITS)) cnt_q <= cnt_q + 1'b1;
  end

  // R10: counter never passes the clearing strobe
  p_cnt_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(SR_BITS));
  p_cnt_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sr_rd_i |=> cnt_q == '0);
endmodule

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int unsigned NF        = 6,
  parameter int unsigned FW        = 8,
  parameter int unsigned PULSE_CYC = 4,
  parameter int unsigned SR_BITS   = 8,
  localparam int unsigned TW = NF * FW,
  localparam int unsigned PW = $clog2(PULSE_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [TW-1:0] time_i,
  input  logic [TW-1:0] alm0_val_i,
  input  logic [NF-1:0] alm0_cmp_i,
  input  logic [TW-1:0] alm1_val_i,
  input  logic [NF-1:0] alm1_cmp_i,
  input  logic [1:0]    alm_en_i,
  input  logic          rpt_mode_i,
  input  logic          fout_en_i,
  input  logic          sr_rd_i,
  input  logic          sr_scl_fall_i,
  output logic [1:0]    flag_o,
  output logic          irq_o
);
  alm_mode_e mode;
  logic [NUM_ALM-1:0][TW-1:0] val_a;
  logic [NUM_ALM-1:0][NF-1:0] cmp_a;
  logic [NUM_ALM-1:0] hit, live, rpt_go, os_go, fire, fired_q, flag_q;
  logic [PW-1:0] pulse_q;
  logic clr;

  assign mode  = alm_mode_e'(rpt_mode_i);
  assign val_a = {alm1_val_i, alm0_val_i};
  assign cmp_a = {alm1_cmp_i, alm0_cmp_i};

  cal_sr_clear #(.SR_BITS(SR_BITS)) u_clr (
    .clk_i, .rst_ni, .sr_rd_i, .sr_scl_fall_i, .clr_o(clr)
  );

  for (genvar k = 0; k < NUM_ALM; k++) begin : g_alm
    cal_alarm_match #(.NF(NF), .FW(FW)) u_match (
      .time_i, .val_i(val_a[k]), .cmp_i(cmp_a[k]), .hit_o(hit[k])
    );

    assign live[k]  = alm_en_i[k] && !fout_en_i;
    assign os_go[k] = live[k] && mode == MODE_ONESHOT && !fired_q[k];
    // alarm 0 has priority in repeating mode
    if (k == 0) begin : g_pri
      assign rpt_go[k] = live[k] && mode == MODE_REPEAT;
    end else begin : g_sub
      assign rpt_go[k] = live[k] && mode == MODE_REPEAT && !alm_en_i[0];
    end
    assign fire[k] = tick_i && hit[k] && (rpt_go[k] || os_go[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   fired_q[k] <= 1'b0;
      else if (!alm_en_i[k] || mode == MODE_REPEAT)  fired_q[k] <= 1'b0;
      else if (fire[k])                              fired_q[k] <= 1'b1;
    end

    // a new match wins over a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      flag_q[k] <= 1'b0;
      else if (fire[k]) flag_q[k] <= 1'b1;
      else if (clr)     flag_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pulse_q <= '0;
    else if (mode != MODE_REPEAT) pulse_q <= '0;
    else if (|fire)               pulse_q <= PW'(PULSE_CYC);
    else if (pulse_q != '0)       pulse_q <= pulse_q - 1'b1;
  end

  assign flag_o = flag_q;
  assign irq_o  = (mode == MODE_REPEAT) ? (pulse_q != '0) : |flag_q;

  p_fout_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fout_en_i |-> fire == '0);
  p_override_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_mode_i && alm_en_i[0]) |-> !fire[1]);
  p_tick_only_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> (flag_q & ~$past(flag_q)) == '0);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && fire == '0) |=> flag_q == '0);
  p_pulse_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q <= PW'(PULSE_CYC));
  p_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_mode_i && alm_en_i == 2'b00) |=> $stable(flag_q) || flag_q == '0);
endmodule

// File: tb/cal_alarm_ctrl_test.sv
module cal_alarm_ctrl_test;
  localparam int NF = 6, FW = 8, PC = 4, TW = NF * FW;

  logic clk = 0, rst_n = 0, tick = 0, rpt = 0, fout = 0, rd = 0, fall = 0;
  logic [TW-1:0] tm = '0, v0 = '0, v1 = '0;
  logic [NF-1:0] c0 = '1, c1 = '1;
  logic [1:0] en = 0, flag;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cal_alarm_ctrl #(.NF(NF), .FW(FW), .PULSE_CYC(PC), .SR_BITS(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tm),
    .alm0_val_i(v0), .alm0_cmp_i(c0), .alm1_val_i(v1), .alm1_cmp_i(c1),
    .alm_en_i(en), .rpt_mode_i(rpt), .fout_en_i(fout), .sr_rd_i(rd),
    .sr_scl_fall_i(fall), .flag_o(flag), .irq_o(irq));

  function automatic logic [TW-1:0] mk(input int base);
    logic [TW-1:0] r;
    for (int n = 0; n < NF; n++) r[n*FW +: FW] = FW'(base + n);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 0; tick = 0; rpt = 0; fout = 0; rd = 0; fall = 0; en = 0;
    c0 = '1; c1 = '1; tm = mk(16); v0 = mk(16); v1 = mk(16);
    cyc(2); rst_n = 1; cyc(1);
  endtask

  task automatic tick1;
    tick = 1; cyc(1); tick = 0;
  endtask

  task automatic sr_read(input int n);
    rd = 1; cyc(1);
    for (int i = 0; i < n; i++) begin
      fall = 1; cyc(1); fall = 0; cyc(1);
    end
    rd = 0; cyc(1);
  endtask

  task automatic t_reset;
    do_reset;
    chk("R12 flag", flag, 0);
    chk("R12 irq", irq, 0);
  endtask

  task automatic t_oneshot;
    do_reset; en = 2'b01;
    tm[8 +: FW] = 8'h99; tick1;
    chk("R1 mismatch no set", flag, 0);
    tm = mk(16); tick1;
    chk("R1 flag set", flag, 2'b01);
    chk("R4 irq level", irq, 1);
    cyc(6);
    chk("R4 irq held", irq, 1);
    sr_read(8);
    chk("R4 irq drops on clear", irq, 0);
  endtask

  task automatic t_mask;
    do_reset; en = 2'b01;
    tm[2*FW +: FW] = 8'hAA; tm[5*FW +: FW] = 8'h55;
    c0 = 6'b011011; tick1;
    chk("R2 masked fields ignored", flag, 2'b01);
  endtask

  task automatic t_notick;
    do_reset; en = 2'b11; cyc(6);
    chk("R3 no tick no flag", flag, 0);
  endtask

  task automatic t_once;
    do_reset; en = 2'b01; tick1;
    chk("R5 first fire", flag, 2'b01);
    sr_read(8);
    chk("R5 cleared", flag, 0);
    tick1;
    chk("R5 no refire", flag, 0);
    en = 2'b00; cyc(1); en = 2'b01; tick1;
    chk("R5 rearmed fires", flag, 2'b01);
  endtask

  task automatic t_both;
    do_reset; en = 2'b11; tick1;
    chk("R6 both flags", flag, 2'b11);
  endtask

  task automatic t_repeat;
    do_reset; rpt = 1; en = 2'b01; tick1;
    chk("R7 flag", flag, 2'b01);
    chk("R7 irq start", irq, 1);
    cyc(PC - 1);
    chk("R7 irq last cycle", irq, 1);
    cyc(1);
    chk("R7 irq ended", irq, 0);
    sr_read(8);
    chk("R7 cleared", flag, 0);
    tick1;
    chk("R7 refire flag", flag, 2'b01);
    chk("R7 refire irq", irq, 1);
  endtask

  task automatic t_override;
    do_reset; rpt = 1; en = 2'b11; tick1;
    chk("R8 only alarm0", flag, 2'b01);
    cyc(PC + 1); sr_read(8);
    en = 2'b10; tick1;
    chk("R8 alarm1 alone", flag, 2'b10);
  endtask

  task automatic t_fout;
    do_reset; fout = 1; en = 2'b11; tick1;
    chk("R9 oneshot blocked", flag, 0);
    rpt = 1; tick1;
    chk("R9 repeat blocked", flag, 0);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_clear;
    do_reset; en = 2'b11; tick1;
    sr_read(7);
    chk("R10 seven strobes keep", flag, 2'b11);
    rd = 1; cyc(1);
    for (int i = 0; i < 4; i++) begin fall = 1; cyc(1); fall = 0; cyc(1); end
    rd = 0; cyc(1);
    sr_read(4);
    chk("R10 split read keeps", flag, 2'b11);
    sr_read(8);
    chk("R10 eighth strobe clears", flag, 0);
  endtask

  task automatic t_stop;
    do_reset; rpt = 1; en = 2'b01; tick1; cyc(PC + 1);
    sr_read(8);
    en = 2'b00; tick1;
    chk("R11 no flag after disable", flag, 0);
    chk("R11 no pulse", irq, 0);
  endtask

  initial begin
    t_reset; t_oneshot; t_mask; t_notick; t_once; t_both;
    t_repeat; t_override; t_fout; t_clear; t_stop;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule